// File: doc/BRIEF.md
# Sequential Byte-Register Multiply/Divide Unit

This unit does an unsigned 16-by-8 multiply or an unsigned 16-by-8 divide over several clock cycles. It serves a small 8-bit processor core. The wide operand is the accumulator byte concatenated above the C byte. The narrow operand is the B byte. A one-cycle start pulse launches an operation, and the operation select is sampled in the same cycle. The operands are captured at that edge, so the core may change its inputs freely while the unit works.

The unit always takes the same number of cycles, whichever operation runs and whatever the data. It then raises a one-cycle done pulse and presents the new B, accumulator and C bytes together with new carry and overflow flags. The core writes these back into its register file. Internally, each cycle retires several multiplier bits or several quotient bits, set by a parameter. An idle tail then pads every operation to the fixed latency.

Top module: `seq_muldiv`

## Requirements
- R1: With `opDiv`=0 (multiply), the result is the 24-bit product {accIn,cIn}×bIn. Its bits 23:16 appear on `bOut`, bits 15:8 on `accOut` and bits 7:0 on `cOut`.
- R2: After a multiply, `cyOut` is 0. `ovOut` is 1 exactly when the product is larger than 0xFFFF.
- R3: With `opDiv`=1 (divide) and bIn nonzero, the 16-bit quotient of {accIn,cIn}/bIn appears with its high byte on `accOut` and its low byte on `cOut`. The remainder appears on `bOut`.
- R4: After a divide by a nonzero value, `cyOut` is 0. `ovOut` is 1 exactly when the remainder is zero.
- R5: A divide with bIn=0 takes the normal latency. It returns `accOut`=`cOut`=0xFF, `bOut` equal to the cIn captured at start, `ovOut`=1 and `cyOut`=0.
- R6: `done` is high for exactly one cycle. It rises on the 7th rising edge after the edge that accepted `start`, for both operations and for every operand value. The results are valid in that cycle.
- R7: A `start` that arrives while an operation is in progress is ignored. It changes neither the timing nor the result of the running operation, even when it comes with different operands or a different `opDiv`.
- R8: After reset, `done` is 0 and all result outputs are 0. Result outputs change only in the cycle in which `done` is high, and they hold their values until the next `done`.
- R9: A `start` presented during the `done` cycle is accepted. This lets operations run back to back with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse; ignored while busy |
| opDiv | input | 1 | 0 = multiply, 1 = divide; sampled with start |
| accIn | input | 8 | Accumulator byte, high half of the wide operand |
| bIn | input | 8 | B byte: multiplier or divisor |
| cIn | input | 8 | C byte, low half of the wide operand |
| bOut | output | 8 | New B: product high byte or remainder |
| accOut | output | 8 | New accumulator: product middle byte or quotient high byte |
| cOut | output | 8 | New C: product low byte or quotient low byte |
| cyOut | output | 1 | New carry flag (always cleared) |
| ovOut | output | 1 | New overflow flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the product boundary where 0x0101×0xFF just fits in 16 bits and 0x0102×0xFF just overflows. A wrong overflow test would flip `ovOut` at one of these points.

Divide by zero, including a zero C byte, exposes a unit that hangs, takes a shortened path or returns an unspecified remainder. Exact divisions check that overflow follows a zero remainder. A dividend smaller than the divisor catches a quotient taken from the wrong shift position.

Starts injected with fresh operands during a running operation would corrupt the result or restart the count in a unit that does not lock them out. Chained operations catch a unit that drops the start arriving in its done cycle.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  // Strobes from the sequencer to the arithmetic datapath.
  typedef struct packed {
    logic load;     // capture operands, clear working state
    logic step;     // retire one group of bits
    logic capture;  // copy the finished result to the outputs
    logic divMode;  // 1 = divide, 0 = multiply (held for the operation)
  } mduCtrl_t;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int LATENCY   = 7,
  parameter int MUL_STEPS = 3,
  parameter int DIV_STEPS = 6
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     opDiv,
  output mduCtrl_t ctrl,
  output logic     done
);

  localparam int CNT_W = $clog2(LATENCY + 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             divMode;
  logic [CNT_W-1:0] stepLimit;
  logic             accept;
  logic             lastCycle;

  assign accept    = start && !busy;
  assign lastCycle = busy && (cnt == CNT_W'(LATENCY));
  assign stepLimit = divMode ? CNT_W'(DIV_STEPS) : CNT_W'(MUL_STEPS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      cnt     <= '0;
      divMode <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= lastCycle;
      if (accept) begin
        busy    <= 1'b1;
        cnt     <= CNT_W'(1);
        divMode <= opDiv;
      end else if (lastCycle) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    ctrl.load    = accept;
    ctrl.step    = busy && (cnt <= stepLimit);
    ctrl.capture = lastCycle;
    ctrl.divMode = divMode;
  end

  // R6: the completion pulse never lasts two cycles
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: a start while busy neither stops nor restarts the count
  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !lastCycle) |=> (busy && cnt == $past(cnt) + CNT_W'(1)));

  // R6: arithmetic never runs in the completion cycle
  assert_step_before_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |-> !ctrl.step);

endmodule

// File: rtl/muldiv_datapath.sv
module muldiv_datapath
  import muldiv_pkg::*;
#(
  parameter int W         = 8,
  parameter int STEP_BITS = 3,
  parameter int MUL_STEPS = 3,
  parameter int DIV_STEPS = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  mduCtrl_t     ctrl,
  input  logic [W-1:0] accIn,
  input  logic [W-1:0] bIn,
  input  logic [W-1:0] cIn,
  output logic [W-1:0] bOut,
  output logic [W-1:0] accOut,
  output logic [W-1:0] cOut,
  output logic         ovOut
);

  localparam int WIDE    = 2 * W;
  localparam int MUL_PAD = MUL_STEPS * STEP_BITS;
  localparam int DIV_PAD = DIV_STEPS * STEP_BITS;
  localparam int PROD_W  = WIDE + MUL_PAD;

  // multiply working state
  logic [WIDE-1:0]    mcand;
  logic [MUL_PAD-1:0] mplier;
  logic [PROD_W-1:0]  prod;
  logic [MUL_PAD-1:0] mplierNext;
  logic [PROD_W-1:0]  prodNext;

  // divide working state
  logic [DIV_PAD-1:0] quo;
  logic [W:0]         rem;
  logic [W-1:0]       divisor;
  logic [DIV_PAD-1:0] quoNext;
  logic [W:0]         remNext;

  // Multiply: MSB-first shift-add over STEP_BITS multiplier bits per cycle.
  always_comb begin
    prodNext = prod << STEP_BITS;
    for (int i = 0; i < STEP_BITS; i++) begin
      if (mplier[MUL_PAD-1-i]) begin
        prodNext = prodNext + (PROD_W'(mcand) << (STEP_BITS - 1 - i));
      end
    end
    mplierNext = mplier << STEP_BITS;
  end

  // Divide: restoring shift-subtract, STEP_BITS quotient bits per cycle.
  always_comb begin
    remNext = rem;
    quoNext = quo;
    for (int i = 0; i < STEP_BITS; i++) begin
      remNext = {remNext[W-1:0], quoNext[DIV_PAD-1]};
      quoNext = {quoNext[DIV_PAD-2:0], 1'b0};
      if (remNext >= {1'b0, divisor}) begin
        remNext    = remNext - {1'b0, divisor};
        quoNext[0] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mcand   <= '0;
      mplier  <= '0;
      prod    <= '0;
      quo     <= '0;
      rem     <= '0;
      divisor <= '0;
    end else if (ctrl.load) begin
      mcand   <= {accIn, cIn};
      mplier  <= MUL_PAD'(bIn);
      prod    <= '0;
      quo     <= DIV_PAD'({accIn, cIn});
      rem     <= '0;
      divisor <= bIn;
    end else if (ctrl.step) begin
      if (ctrl.divMode) begin
        quo <= quoNext;
        rem <= remNext;
      end else begin
        prod   <= prodNext;
        mplier <= mplierNext;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bOut   <= '0;
      accOut <= '0;
      cOut   <= '0;
      ovOut  <= 1'b0;
    end else if (ctrl.capture) begin
      if (ctrl.divMode) begin
        accOut <= quo[WIDE-1:W];
        cOut   <= quo[W-1:0];
        bOut   <= rem[W-1:0];
        ovOut  <= (rem[W-1:0] == '0) || (divisor == '0);
      end else begin
        bOut   <= prod[3*W-1:WIDE];
        accOut <= prod[WIDE-1:W];
        cOut   <= prod[W-1:0];
        ovOut  <= |prod[PROD_W-1:WIDE];
      end
    end
  end

  // R2: multiply overflow tracks a nonzero top byte
  assert_mul_ov_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.capture && !ctrl.divMode) |=> (ovOut == (bOut != '0)));

  // R4: the remainder is always below a nonzero divisor
  assert_div_rem_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.capture && ctrl.divMode && divisor != '0) |=> (bOut < $past(divisor)));

  // R5: divide by zero gives an all-ones quotient and sets overflow
  assert_div_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.capture && ctrl.divMode && divisor == '0) |=> (ovOut && accOut == '1 && cOut == '1));

  // R8: results move only on capture
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> $stable({bOut, accOut, cOut, ovOut}));

  generate
    if (DIV_PAD > WIDE) begin : g_quoPad
      // R3: padding quotient bits stay clear for a nonzero divisor
      assert_quo_pad_R3: assert property (@(posedge clk) disable iff (!rstN)
        (ctrl.capture && ctrl.divMode && divisor != '0) |-> (quo[DIV_PAD-1:WIDE] == '0));
    end
  endgenerate

endmodule

// File: rtl/seq_muldiv.sv
module seq_muldiv
  import muldiv_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LATENCY   = 7,
  parameter int STEP_BITS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              opDiv,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic [DATA_W-1:0] cIn,
  output logic [DATA_W-1:0] bOut,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] cOut,
  output logic              cyOut,
  output logic              ovOut,
  output logic              done
);

  localparam int MUL_STEPS = (DATA_W + STEP_BITS - 1) / STEP_BITS;
  localparam int DIV_STEPS = (2 * DATA_W + STEP_BITS - 1) / STEP_BITS;
  localparam int CNT_W     = $clog2(LATENCY + 1);

  mduCtrl_t ctrl;

  muldiv_ctrl #(
    .LATENCY  (LATENCY),
    .MUL_STEPS(MUL_STEPS),
    .DIV_STEPS(DIV_STEPS)
  ) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .opDiv(opDiv),
    .ctrl (ctrl),
    .done (done)
  );

  muldiv_datapath #(
    .W        (DATA_W),
    .STEP_BITS(STEP_BITS),
    .MUL_STEPS(MUL_STEPS),
    .DIV_STEPS(DIV_STEPS)
  ) u_datapath (
    .clk   (clk),
    .rstN  (rstN),
    .ctrl  (ctrl),
    .accIn (accIn),
    .bIn   (bIn),
    .cIn   (cIn),
    .bOut  (bOut),
    .accOut(accOut),
    .cOut  (cOut),
    .ovOut (ovOut)
  );

  // Both operations clear the carry flag (R2, R4).
  assign cyOut = 1'b0;

  // Independent latency watch for R6.
  logic             armed;
  logic [CNT_W-1:0] sinceAccept;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed       <= 1'b0;
      sinceAccept <= '0;
    end else if (ctrl.load) begin
      armed       <= 1'b1;
      sinceAccept <= '0;
    end else if (done) begin
      armed <= 1'b0;
    end else if (armed && sinceAccept < CNT_W'(LATENCY)) begin
      sinceAccept <= sinceAccept + CNT_W'(1);
    end
  end

  // R6: done comes exactly LATENCY edges after the accepting edge
  assert_done_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (armed && sinceAccept == CNT_W'(LATENCY)));

endmodule

// File: tb/seq_muldiv_bench.sv
module seq_muldiv_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       opDiv = 1'b0;
  logic [7:0] accIn = '0;
  logic [7:0] bIn = '0;
  logic [7:0] cIn = '0;
  logic [7:0] bOut, accOut, cOut;
  logic       cyOut, ovOut, done;

  int unsigned nChecks = 0;
  int unsigned nFails = 0;
  bit          finished = 1'b0;

  logic [7:0] expB, expAcc, expC;
  logic       expOv;

  always #10 clk = ~clk;  // 50 MHz

  seq_muldiv u_seq_muldiv (
    .clk(clk), .rstN(rstN), .start(start), .opDiv(opDiv),
    .accIn(accIn), .bIn(bIn), .cIn(cIn),
    .bOut(bOut), .accOut(accOut), .cOut(cOut),
    .cyOut(cyOut), .ovOut(ovOut), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  // Reference model taken from R1..R5.
  task automatic model(input bit div, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] c);
    logic [23:0] p;
    logic [15:0] q;
    logic [7:0]  r;
    if (!div) begin
      p      = 24'({a, c}) * 24'(b);
      expB   = p[23:16];
      expAcc = p[15:8];
      expC   = p[7:0];
      expOv  = (p > 24'hFFFF);
    end else if (b == 8'd0) begin
      expAcc = 8'hFF;
      expC   = 8'hFF;
      expB   = c;
      expOv  = 1'b1;
    end else begin
      q      = {a, c} / 16'(b);
      r      = 8'({a, c} % 16'(b));
      expAcc = q[15:8];
      expC   = q[7:0];
      expB   = r;
      expOv  = (r == 8'd0);
    end
  endtask

  // Called at a negedge; returns at the negedge of the done cycle.
  task automatic runOp(input bit div, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] c, input bit disturb);
    bit early;
    string rq;
    early = 1'b0;
    model(div, a, b, c);
    opDiv = div; accIn = a; bIn = b; cIn = c; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= 7; k++) begin
      if (disturb && k < 7) begin
        // R7: start during busy with different operands
        start = 1'b1; opDiv = ~div;
        accIn = 8'($urandom); bIn = 8'($urandom); cIn = 8'($urandom);
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (k < 7 && done) early = 1'b1;
    end
    check(!early, "R6", "done before 7th edge", 32'(early), 0);
    check(done == 1'b1, disturb ? "R7" : "R6", "done on 7th edge", 32'(done), 1);
    rq = div ? ((b == 8'd0) ? "R5" : "R3") : "R1";
    check({bOut, accOut, cOut} == {expB, expAcc, expC}, rq, "B/ACC/C",
          32'({bOut, accOut, cOut}), 32'({expB, expAcc, expC}));
    rq = div ? ((b == 8'd0) ? "R5" : "R4") : "R2";
    check(ovOut == expOv, rq, "OV", 32'(ovOut), 32'(expOv));
    check(cyOut == 1'b0, rq, "CY", 32'(cyOut), 0);
  endtask

  // R8: results hold and done stays low after the pulse.
  task automatic holdCheck(input int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(posedge clk);
      @(negedge clk);
      check(done == 1'b0, "R8", "done after pulse", 32'(done), 0);
      check({bOut, accOut, cOut, ovOut} == {expB, expAcc, expC, expOv}, "R8",
            "held result", 32'({bOut, accOut, cOut, ovOut}),
            32'({expB, expAcc, expC, expOv}));
    end
  endtask

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check({bOut, accOut, cOut, ovOut, done} == '0, "R8", "reset state",
          32'({bOut, accOut, cOut, ovOut, done}), 0);

    // R1/R2 directed multiplies around the 16-bit boundary
    runOp(1'b0, 8'hFF, 8'hFF, 8'hFF, 1'b0); holdCheck(2);
    runOp(1'b0, 8'h01, 8'hFF, 8'h01, 1'b0); holdCheck(1);
    runOp(1'b0, 8'h01, 8'hFF, 8'h02, 1'b0);
    runOp(1'b0, 8'h12, 8'h00, 8'h34, 1'b0);
    // R3/R4 directed divides
    runOp(1'b1, 8'h12, 8'h02, 8'h34, 1'b0);
    runOp(1'b1, 8'hFF, 8'h01, 8'hFF, 1'b0);
    runOp(1'b1, 8'h00, 8'h09, 8'h05, 1'b0);
    runOp(1'b1, 8'hAB, 8'hFF, 8'hCD, 1'b0); holdCheck(3);
    // R5 divide by zero
    runOp(1'b1, 8'h77, 8'h00, 8'h5A, 1'b0);
    runOp(1'b1, 8'h00, 8'h00, 8'h00, 1'b0); holdCheck(1);
    // R7 starts while busy
    runOp(1'b0, 8'hC3, 8'h9E, 8'h21, 1'b1);
    runOp(1'b1, 8'hC3, 8'h07, 8'h21, 1'b1); holdCheck(1);
    // R9 back-to-back: next start presented in the done cycle
    runOp(1'b1, 8'h40, 8'h03, 8'h01, 1'b0);
    runOp(1'b0, 8'h40, 8'h03, 8'h01, 1'b0);
    runOp(1'b1, 8'h00, 8'h00, 8'hE1, 1'b0);

    for (int n = 0; n < 300; n++) begin
      logic [7:0] rb;
      rb = 8'($urandom);
      if (($urandom % 10) == 0) rb = 8'd0;
      runOp(1'($urandom), 8'($urandom), rb, 8'($urandom), (($urandom % 8) == 0));
      if (($urandom % 2) == 0) holdCheck(1);
    end
    finishRun();
  end

endmodule